// File: doc/BRIEF.md
# Indirect-Access Memory Controller Register File

This block is the configuration and status register file of a DRAM controller. Software reaches it through two device-control ports. Writing the index port stores the offset of an internal register. Reading or writing the data port then acts on the register that the stored index selects. Behind the data port sit the following registers:

- two bus-error status words, which are write-one-to-clear;
- a bus-error address word;
- the controller configuration word and a read-only status word;
- refresh and power-management timer words;
- a timing word;
- an ECC configuration word and an ECC error-status word;
- one configuration word per memory bank.

Bit 31 of the configuration word drives the global controller enable. Each write to a bank word is passed to the bank decoder through a one-cycle strobe, together with the bank number and the written value. A nonzero ECC error-status word holds a level interrupt high.

Top module: `memctl_csr_bank`

## Requirements
- R1: A write to port 0x010 stores the full 32-bit index, and reading port 0x010 returns it. Reading port 0x011 returns the register selected by the index. Reading any other port returns 0.
- R2: After reset the data port reads 0x00800000 at offset 0x20, 0x05F00000 at 0x30 and 0x07C00000 at 0x34. Every other mapped offset reads 0, and the interrupt, the enable and the bank strobe are low.
- R3: The error status words at offsets 0x00 and 0x08 are write-one-to-clear. A write never sets any of their bits, so both read 0 after any write.
- R4: The error address word at offset 0x10 stores and returns all 32 bits written to it.
- R5: A configuration write (offset 0x20) keeps only the bits in 0xFFE00000. When bit 31 changes from 0 to 1, status bit 31 is cleared. When bit 31 changes from 1 to 0, status bit 31 is set. The `ctrl_enable` output follows configuration bit 31.
- R6: When configuration bit 30 changes from 0 to 1, status bit 30 is set. When it changes from 1 to 0, status bit 30 is cleared. Writes to the status word at offset 0x24 have no effect.
- R7: Writes are masked as follows: the refresh timer (0x30) keeps the bits in 0x3FF80000, and the ECC configuration (0x94) keeps the bits in 0x00F00000. The power timer (0x34) keeps bits 31:27 of the written value, with 0x07C00000 always ORed in.
- R8: The ECC error-status word (0x98) keeps the bits in 0xFFF0F000. `ecc_irq` is set when this word changes from zero to nonzero, is cleared when it returns to zero, and otherwise holds its level.
- R9: Reading the timing offset 0x80, or any offset that maps to no register (including unaligned offsets), returns 0xFFFFFFFF. Writes to such offsets change no readable register.
- R10: A data-port write at offset 0x40 + 4·k, where k is less than the bank count, stores the value so that it reads back. In the cycle after the write, it also raises `bank_wr_stb` for exactly one cycle, with `bank_wr_sel` = k and `bank_wr_data` equal to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Port access qualifier |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_port | input | PORT_W (10) | Device-control port number |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for `acc_port` (combinational) |
| ctrl_enable | output | 1 | Global controller enable |
| bank_wr_stb | output | 1 | One-cycle bank word write strobe |
| bank_wr_sel | output | SEL_W (2) | Bank number of the strobed write |
| bank_wr_data | output | 32 | Value of the strobed write |
| ecc_irq | output | 1 | Level interrupt while ECC error status is nonzero |

## Verification
The bench builds the block with its default values: a 10-bit port number, four banks and bank words starting at offset 0x40. With these values the whole index range 0x00 to 0xFF is small enough to sweep one offset at a time. That sweep covers every mapped register, every unaligned or unmapped hole, and every bank strobe number. Several data patterns are then written at each aligned offset. This drives both edges of configuration bits 31 and 30 and both edges of the ECC interrupt.

// File: rtl/memctl_csr_pkg.sv
package memctl_csr_pkg;

  localparam logic [31:0] OFS_ERRST0  = 32'h00;
  localparam logic [31:0] OFS_ERRST1  = 32'h08;
  localparam logic [31:0] OFS_ERRADDR = 32'h10;
  localparam logic [31:0] OFS_CFG     = 32'h20;
  localparam logic [31:0] OFS_STAT    = 32'h24;
  localparam logic [31:0] OFS_RFSH    = 32'h30;
  localparam logic [31:0] OFS_PWR     = 32'h34;
  localparam logic [31:0] OFS_TIMING  = 32'h80;
  localparam logic [31:0] OFS_ECCCFG  = 32'h94;
  localparam logic [31:0] OFS_ECCST   = 32'h98;

  localparam logic [31:0] MSK_CFG    = 32'hFFE0_0000;
  localparam logic [31:0] MSK_RFSH   = 32'h3FF8_0000;
  localparam logic [31:0] MSK_ECCCFG = 32'h00F0_0000;
  localparam logic [31:0] MSK_ECCST  = 32'hFFF0_F000;
  localparam logic [31:0] MSK_PWR    = 32'hF800_0000;
  localparam logic [31:0] PWR_FORCE  = 32'h07C0_0000;

  localparam logic [31:0] RST_CFG  = 32'h0080_0000;
  localparam logic [31:0] RST_RFSH = 32'h05F0_0000;
  localparam logic [31:0] RST_PWR  = 32'h07C0_0000;
  localparam logic [31:0] RD_NONE  = 32'hFFFF_FFFF;

  // power timer: upper five bits kept, fixed field always forced on
  function automatic logic [31:0] pwr_fold(input logic [31:0] v);
    return (v & MSK_PWR) | PWR_FORCE;
  endfunction

  // write-one-to-clear update
  function automatic logic [31:0] w1c(input logic [31:0] cur, input logic [31:0] v);
    return cur & ~v;
  endfunction

  // status update from a configuration transition (bit 31 inverted, bit 30 follows)
  function automatic logic [31:0] stat_next(input logic [31:0] cfg_old,
                                            input logic [31:0] cfg_new,
                                            input logic [31:0] st);
    logic [31:0] s;
    s = st;
    if (!cfg_old[31] && cfg_new[31]) s[31] = 1'b0;
    else if (cfg_old[31] && !cfg_new[31]) s[31] = 1'b1;
    if (!cfg_old[30] && cfg_new[30]) s[30] = 1'b1;
    else if (cfg_old[30] && !cfg_new[30]) s[30] = 1'b0;
    return s;
  endfunction

endpackage

// File: rtl/csr_access_decode.sv
module csr_access_decode #(
  parameter int PORT_W = 10,
  parameter logic [PORT_W-1:0] INDEX_PORT = 10'h010,
  parameter logic [PORT_W-1:0] DATA_PORT  = 10'h011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [PORT_W-1:0] acc_port,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       index_q,
  output logic              on_index,
  output logic              on_data,
  output logic              data_wr
);

  logic index_wr;

  assign on_index = (acc_port == INDEX_PORT);
  assign on_data  = (acc_port == DATA_PORT);
  assign index_wr = acc_valid && acc_write && on_index;
  assign data_wr  = acc_valid && acc_write && on_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) index_q <= '0;
    else if (index_wr) index_q <= acc_wdata;
  end

  p_index_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    index_wr |=> index_q == $past(acc_wdata));

endmodule

// File: rtl/csr_cfg_status.sv
module csr_cfg_status
  import memctl_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] wdata,
  output logic [31:0] cfg_q,
  output logic [31:0] stat_q
);

  logic [31:0] cfg_new;

  assign cfg_new = wdata & MSK_CFG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= RST_CFG;
      stat_q <= '0;
    end else if (cfg_wr) begin
      cfg_q  <= cfg_new;
      stat_q <= stat_next(cfg_q, cfg_new, stat_q);
    end
  end

  p_enable_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_q[31] && wdata[31]) |=> !stat_q[31]);
  p_enable_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_q[31] && !wdata[31]) |=> stat_q[31]);
  p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(stat_q));

endmodule

// File: rtl/csr_ecc_irq.sv
module csr_ecc_irq
  import memctl_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        esr_wr,
  input  logic [31:0] wdata,
  output logic [31:0] esr_q,
  output logic        irq_q
);

  logic [31:0] esr_new;
  logic        irq_raise;
  logic        irq_lower;

  assign esr_new   = wdata & MSK_ECCST;
  assign irq_raise = esr_wr && (esr_q == '0) && (esr_new != '0);
  assign irq_lower = esr_wr && (esr_q != '0) && (esr_new == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (esr_wr) esr_q <= esr_new;
      if (irq_raise) irq_q <= 1'b1;
      else if (irq_lower) irq_q <= 1'b0;
    end
  end

  p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (esr_q != '0));
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_raise |=> $rose(irq_q));

endmodule

// File: rtl/memctl_csr_bank.sv
module memctl_csr_bank
  import memctl_csr_pkg::*;
#(
  parameter int PORT_W = 10,
  parameter logic [PORT_W-1:0] INDEX_PORT = 10'h010,
  parameter logic [PORT_W-1:0] DATA_PORT  = 10'h011,
  parameter int NUM_BANKS = 4,
  parameter logic [31:0] BANK_BASE = 32'h40,
  localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [PORT_W-1:0] acc_port,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              ctrl_enable,
  output logic              bank_wr_stb,
  output logic [SEL_W-1:0]  bank_wr_sel,
  output logic [31:0]       bank_wr_data,
  output logic              ecc_irq
);

  localparam logic [31:0] BANK_SPAN = 32'(4 * NUM_BANKS);

  logic [31:0]      index_q;
  logic             on_index, on_data, data_wr;
  logic [31:0]      cfg_q, stat_q, esr_q;
  logic [31:0]      err0_q, err1_q, eaddr_q, rfsh_q, pwr_q, ecccfg_q;
  logic [31:0]      bank_q [NUM_BANKS];
  logic [31:0]      bank_off;
  logic             bank_hit;
  logic             bank_go;
  logic [SEL_W-1:0] bank_idx;
  logic [31:0]      data_rd;

  csr_access_decode #(
    .PORT_W(PORT_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_port(acc_port), .acc_wdata(acc_wdata), .index_q(index_q),
    .on_index(on_index), .on_data(on_data), .data_wr(data_wr)
  );

  csr_cfg_status u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(data_wr && index_q == OFS_CFG),
    .wdata(acc_wdata), .cfg_q(cfg_q), .stat_q(stat_q)
  );

  csr_ecc_irq u_ecc (
    .clk(clk), .rst_n(rst_n), .esr_wr(data_wr && index_q == OFS_ECCST),
    .wdata(acc_wdata), .esr_q(esr_q), .irq_q(ecc_irq)
  );

  assign ctrl_enable = cfg_q[31];

  // plain registers behind the data port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err0_q   <= '0;
      err1_q   <= '0;
      eaddr_q  <= '0;
      rfsh_q   <= RST_RFSH;
      pwr_q    <= RST_PWR;
      ecccfg_q <= '0;
    end else if (data_wr) begin
      case (index_q)
        OFS_ERRST0:  err0_q   <= w1c(err0_q, acc_wdata);
        OFS_ERRST1:  err1_q   <= w1c(err1_q, acc_wdata);
        OFS_ERRADDR: eaddr_q  <= acc_wdata;
        OFS_RFSH:    rfsh_q   <= acc_wdata & MSK_RFSH;
        OFS_PWR:     pwr_q    <= pwr_fold(acc_wdata);
        OFS_ECCCFG:  ecccfg_q <= acc_wdata & MSK_ECCCFG;
        default: ;
      endcase
    end
  end

  // bank word window
  assign bank_off = index_q - BANK_BASE;
  assign bank_hit = (bank_off < BANK_SPAN) && (bank_off[1:0] == 2'b00);
  assign bank_idx = bank_off[SEL_W+1:2];
  assign bank_go  = data_wr && bank_hit;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q[g] <= '0;
      else if (bank_go && bank_idx == SEL_W'(g)) bank_q[g] <= acc_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_wr_stb  <= 1'b0;
      bank_wr_sel  <= '0;
      bank_wr_data <= '0;
    end else begin
      bank_wr_stb <= bank_go;
      if (bank_go) begin
        bank_wr_sel  <= bank_idx;
        bank_wr_data <= acc_wdata;
      end
    end
  end

  // read path
  always_comb begin
    data_rd = RD_NONE;
    if (bank_hit) data_rd = bank_q[bank_idx];
    else begin
      case (index_q)
        OFS_ERRST0:  data_rd = err0_q;
        OFS_ERRST1:  data_rd = err1_q;
        OFS_ERRADDR: data_rd = eaddr_q;
        OFS_CFG:     data_rd = cfg_q;
        OFS_STAT:    data_rd = stat_q;
        OFS_RFSH:    data_rd = rfsh_q;
        OFS_PWR:     data_rd = pwr_q;
        OFS_ECCCFG:  data_rd = ecccfg_q;
        OFS_ECCST:   data_rd = esr_q;
        default:     data_rd = RD_NONE;
      endcase
    end
  end

  always_comb begin
    if (on_index)     acc_rdata = index_q;
    else if (on_data) acc_rdata = data_rd;
    else              acc_rdata = '0;
  end

  p_bank_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bank_go |=> bank_wr_stb && bank_wr_data == $past(acc_wdata) && bank_wr_sel == $past(bank_idx));
  p_bank_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_go |=> !bank_wr_stb);
  p_enable_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && index_q == OFS_CFG) |=> ctrl_enable == $past(acc_wdata[31]));

endmodule

// File: tb/memctl_csr_bank_tb.sv
module memctl_csr_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [9:0]  acc_port = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        ctrl_enable;
  logic        bank_wr_stb;
  logic [1:0]  bank_wr_sel;
  logic [31:0] bank_wr_data;
  logic        ecc_irq;

  int checks = 0;
  int failures = 0;

  // bench-side expected state
  logic [31:0] m_eaddr, m_cfg, m_stat, m_rfsh, m_pwr, m_ecccfg, m_eccst;
  logic [31:0] m_bank [4];

  memctl_csr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_port(acc_port), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .ctrl_enable(ctrl_enable), .bank_wr_stb(bank_wr_stb), .bank_wr_sel(bank_wr_sel),
    .bank_wr_data(bank_wr_data), .ecc_irq(ecc_irq)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_port(input logic [9:0] p, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_port = p; acc_wdata = d;
    @(posedge clk);
    #1 acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd_port(input logic [9:0] p, output logic [31:0] d);
    acc_port = p; acc_valid = 1'b1; acc_write = 1'b0;
    #1 d = acc_rdata;
    acc_valid = 1'b0;
  endtask

  function automatic logic [31:0] exp_read(input logic [31:0] o);
    if (o >= 32'h40 && o < 32'h50 && o[1:0] == 2'b00) return m_bank[(o - 32'h40) >> 2];
    case (o)
      32'h00, 32'h08: return 32'h0;
      32'h10: return m_eaddr;
      32'h20: return m_cfg;
      32'h24: return m_stat;
      32'h30: return m_rfsh;
      32'h34: return m_pwr;
      32'h94: return m_ecccfg;
      32'h98: return m_eccst;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic model_write(input logic [31:0] o, input logic [31:0] v);
    logic [31:0] nc;
    if (o >= 32'h40 && o < 32'h50 && o[1:0] == 2'b00) m_bank[(o - 32'h40) >> 2] = v;
    case (o)
      32'h10: m_eaddr = v;
      32'h20: begin
        nc = {v[31:21], 21'h0};
        if (nc[31] != m_cfg[31]) m_stat[31] = m_cfg[31];
        if (nc[30] != m_cfg[30]) m_stat[30] = nc[30];
        m_cfg = nc;
      end
      32'h30: m_rfsh = v & 32'h3FF8_0000;
      32'h34: m_pwr = {v[31:27], 5'b11111, 22'h0};
      32'h94: m_ecccfg = v & 32'h00F0_0000;
      32'h98: m_eccst = v & 32'hFFF0_F000;
      default: ;
    endcase
  endtask

  // write one data value at offset o and check readback and side outputs
  task automatic poke_and_check(input logic [31:0] o, input logic [31:0] v);
    logic [31:0] d;
    logic bank;
    bank = (o >= 32'h40 && o < 32'h50 && o[1:0] == 2'b00);
    wr_port(10'h010, o);
    wr_port(10'h011, v);
    model_write(o, v);
    check("R10 strobe", {31'h0, bank_wr_stb}, {31'h0, bank});
    if (bank) begin
      check("R10 sel", {30'h0, bank_wr_sel}, (o - 32'h40) >> 2);
      check("R10 data", bank_wr_data, v);
    end
    rd_port(10'h011, d);
    if (o == 32'h00 || o == 32'h08) check("R3 w1c", d, exp_read(o));
    else if (o == 32'h20 || o == 32'h24) check("R5 R6 cfg/status", d, exp_read(o));
    else if (o == 32'h98) check("R8 ecc status", d, exp_read(o));
    else if (bank) check("R10 readback", d, exp_read(o));
    else if (o == 32'h10) check("R4 err addr", d, exp_read(o));
    else if (o == 32'h30 || o == 32'h34 || o == 32'h94) check("R7 masks", d, exp_read(o));
    else check("R9 unmapped", d, exp_read(o));
    check("R5 enable", {31'h0, ctrl_enable}, {31'h0, m_cfg[31]});
    check("R8 irq", {31'h0, ecc_irq}, {31'h0, (m_eccst != 0)});
    @(posedge clk); #1;
    check("R10 one-cycle", {31'h0, bank_wr_stb}, 32'h0);
  endtask

  task automatic full_sweep(input string tag);
    logic [31:0] d;
    for (int o = 0; o < 256; o++) begin
      wr_port(10'h010, 32'(o));
      rd_port(10'h010, d);
      check("R1 index", d, 32'(o));
      rd_port(10'h011, d);
      if (d !== exp_read(32'(o))) $display("  at offset %h (%s)", o, tag);
      check("R9/R2 sweep", d, exp_read(32'(o)));
    end
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000;
    pats[2] = 32'h5A5A_A5A5; pats[3] = 32'hC3C3_3C3C;
    m_eaddr = 0; m_cfg = 32'h0080_0000; m_stat = 0; m_rfsh = 32'h05F0_0000;
    m_pwr = 32'h07C0_0000; m_ecccfg = 0; m_eccst = 0;
    for (int b = 0; b < 4; b++) m_bank[b] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2 enable", {31'h0, ctrl_enable}, 32'h0);
    check("R2 irq", {31'h0, ecc_irq}, 32'h0);
    check("R2 strobe", {31'h0, bank_wr_stb}, 32'h0);
    rd_port(10'h010, d); check("R2 index", d, 32'h0);
    rd_port(10'h012, d); check("R1 other port", d, 32'h0);
    rd_port(10'h000, d); check("R1 other port", d, 32'h0);
    full_sweep("reset");
    // R5 R6 edges of configuration bits
    poke_and_check(32'h20, 32'h8000_0000);
    poke_and_check(32'h20, 32'hC000_0000);
    poke_and_check(32'h20, 32'h4000_0000);
    poke_and_check(32'h20, 32'h0000_0000);
    poke_and_check(32'h24, 32'hFFFF_FFFF);
    // R8 irq on/off
    poke_and_check(32'h98, 32'h000F_0FFF);
    poke_and_check(32'h98, 32'h0000_1000);
    poke_and_check(32'h98, 32'h8000_0000);
    poke_and_check(32'h98, 32'h0000_0000);
    // pattern sweep across every aligned offset
    for (int p = 0; p < 4; p++) begin
      for (int o = 0; o < 256; o += 4) poke_and_check(32'(o), pats[p] ^ 32'(o));
    end
    // unaligned offsets near banks: no strobe, no effect
    poke_and_check(32'h41, 32'h1234_5678);
    poke_and_check(32'h4E, 32'h1234_5678);
    full_sweep("final");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule